// File: doc/BRIEF.md
# Programmable AND-Plane Logic Array

This block evaluates a small two-level sum-of-products network whose AND plane is set at run time and whose OR plane is fixed. Four primary inputs and four outputs are served by twelve product terms. The terms fall into four groups of three, and each output is the OR of its own group. Any term may connect any primary input, in true or complemented form. A term may also connect a lower-numbered output in either polarity, so one output can serve as a sub-expression of another. This lets a multi-level function be built inside the array, or a function that needs more than three product terms be split across outputs.

The connection map lives in a register file with one 16-bit connect mask per product term. It is loaded through a plain write port: a strobe, a term address and a mask word. Evaluation from `pal_in` to `pal_out` is purely combinational and reflects the map held in the registers. A write changes the map on the clock edge that samples it. The evaluation path carries no handshake: the array answers in every cycle, so back-pressure does not arise. The configuration port is a single-cycle write that is always accepted or silently dropped, and it has no ready signal.

Top module: `pal_array_top`

## Requirements
- R1: Output k (k = 0..3) is the OR of product terms 3k, 3k+1 and 3k+2. Each product term is the AND of every literal whose mask bit is 1.
- R2: Mask bit positions: bit 2i is pal_in[i] true and bit 2i+1 is pal_in[i] complemented (i = 0..3). Bit 8+2j is pal_out[j] true and bit 9+2j is pal_out[j] complemented (j = 0..3).
- R3: A product term with an all-zero mask evaluates to 1. A term that connects both a literal and its complement evaluates to 0.
- R4: Synchronous active-high reset clears every mask, so every output reads 1 while the map is all open.
- R5: When cfg_we is 1 at a rising clock edge, cfg_data becomes the mask of term cfg_addr, and it affects pal_out only after that edge. During the cycle in which the write is presented, pal_out still follows the old map.
- R6: A write whose cfg_addr is 12 or above is ignored, and no mask changes.
- R7: A term of group k may connect only feedback literals of outputs j < k. A write that sets any feedback bit of output k or above (bit 8+2k and higher) is ignored as a whole, and the term keeps its previous mask. A write that respects the rule is accepted.
- R8: With no accepted write, pal_out depends only on pal_in: equal inputs give equal outputs in every cycle.
- R9: Feedback literals let outputs build on each other. For example, out2 = AD + BD + out0 and out3 = AB + CD + out0', with A..D on pal_in[0..3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset, clears the map |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Product term index to write |
| cfg_data | input | 16 | Connect mask for the addressed term |
| pal_in | input | 4 | Primary inputs |
| pal_out | output | 4 | Combinational array outputs |

## Verification
A configuration write and an evaluation can fall in the same cycle. The bench provokes this by presenting new inputs together with a mask write that changes the value of the selected output for those inputs. It judges the cycle as follows: the output sampled before the edge must follow the old map, and the output sampled after the edge must follow the new one. Rejected writes (address out of range, or forbidden feedback) are also issued between evaluations. The outputs that follow must be unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // default geometry of the array
  localparam int PAL_N_IN  = 4;
  localparam int PAL_N_OUT = 4;
  localparam int PAL_TPO   = 3;

  // polarity offset of a literal inside its bit pair
  typedef enum logic {
    LIT_TRUE = 1'b0,
    LIT_COMP = 1'b1
  } lit_pol_e;
endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store
  import pal_pkg::*;
#(
  parameter int N_IN  = PAL_N_IN,
  parameter int N_OUT = PAL_N_OUT,
  parameter int TPO   = PAL_TPO,
  localparam int N_TERMS = N_OUT * TPO,
  localparam int MASK_W  = 2 * (N_IN + N_OUT),
  localparam int ADDR_W  = $clog2(N_TERMS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [MASK_W-1:0]           data,
  output logic [N_TERMS*MASK_W-1:0]   map_flat
);
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    localparam int GRP   = t / TPO;
    localparam int LIMIT = 2 * N_IN + 2 * GRP;
    // bits at or above LIMIT are feedback of this group or later ones
    localparam logic [MASK_W-1:0] ALLOW = (MASK_W'(1) << LIMIT) - MASK_W'(1);

    logic [MASK_W-1:0] mask_q;
    logic              legal;
    logic              hit;

    always_comb begin
      legal = ((data & ~ALLOW) == '0);
      hit   = we && (addr == ADDR_W'(t)) && legal;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= '0;
      end else if (hit) begin
        mask_q <= data;
      end
    end

    assign map_flat[t*MASK_W +: MASK_W] = mask_q;
  end
endmodule

// File: rtl/pal_product_term.sv
module pal_product_term
  import pal_pkg::*;
#(
  parameter int N_IN  = PAL_N_IN,
  parameter int N_OUT = PAL_N_OUT,
  localparam int MASK_W = 2 * (N_IN + N_OUT)
) (
  input  logic [N_IN-1:0]   in_v,
  input  logic [N_OUT-1:0]  fb_v,
  input  logic [MASK_W-1:0] mask,
  output logic              term
);
  logic [MASK_W-1:0] lit;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      lit[2*i + int'(LIT_TRUE)] = in_v[i];
      lit[2*i + int'(LIT_COMP)] = ~in_v[i];
    end
    for (int j = 0; j < N_OUT; j++) begin
      lit[2*N_IN + 2*j + int'(LIT_TRUE)] = fb_v[j];
      lit[2*N_IN + 2*j + int'(LIT_COMP)] = ~fb_v[j];
    end
    // open connections contribute a 1 to the AND
    term = &(lit | ~mask);
  end
endmodule

// File: rtl/pal_group_eval.sv
module pal_group_eval
  import pal_pkg::*;
#(
  parameter int N_IN  = PAL_N_IN,
  parameter int N_OUT = PAL_N_OUT,
  parameter int TPO   = PAL_TPO,
  localparam int MASK_W = 2 * (N_IN + N_OUT)
) (
  input  logic [N_IN-1:0]       in_v,
  input  logic [N_OUT-1:0]      fb_v,
  input  logic [TPO*MASK_W-1:0] masks,
  output logic                  y
);
  logic [TPO-1:0] terms;

  for (genvar p = 0; p < TPO; p++) begin : g_pt
    pal_product_term #(
      .N_IN (N_IN),
      .N_OUT(N_OUT)
    ) u_pt (
      .in_v (in_v),
      .fb_v (fb_v),
      .mask (masks[p*MASK_W +: MASK_W]),
      .term (terms[p])
    );
  end

  assign y = |terms;
endmodule

// File: rtl/pal_array_top.sv
module pal_array_top
  import pal_pkg::*;
#(
  parameter int N_IN  = PAL_N_IN,
  parameter int N_OUT = PAL_N_OUT,
  parameter int TPO   = PAL_TPO,
  localparam int N_TERMS = N_OUT * TPO,
  localparam int MASK_W  = 2 * (N_IN + N_OUT),
  localparam int ADDR_W  = $clog2(N_TERMS),
  localparam int GRP_W   = TPO * MASK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [MASK_W-1:0] cfg_data,
  input  logic [N_IN-1:0]   pal_in,
  output logic [N_OUT-1:0]  pal_out
);
  logic [N_TERMS*MASK_W-1:0] map_flat;

  pal_fuse_store #(
    .N_IN (N_IN),
    .N_OUT(N_OUT),
    .TPO  (TPO)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .data    (cfg_data),
    .map_flat(map_flat)
  );

  // each group sees only the outputs of the groups before it
  for (genvar g = 0; g < N_OUT; g++) begin : g_grp
    logic [N_OUT-1:0] lower;
    logic             y;

    if (g == 0) begin : g_first
      assign lower = '0;
    end else begin : g_next
      assign lower = g_grp[g-1].lower | (N_OUT'(g_grp[g-1].y) << (g - 1));
    end

    pal_group_eval #(
      .N_IN (N_IN),
      .N_OUT(N_OUT),
      .TPO  (TPO)
    ) u_grp (
      .in_v (pal_in),
      .fb_v (lower),
      .masks(map_flat[g*GRP_W +: GRP_W]),
      .y    (y)
    );

    assign pal_out[g] = y;
  end
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int TPO    = 3,
  parameter int ADDR_W = 4,
  parameter int MASK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [MASK_W-1:0] cfg_data,
  input logic [N_IN-1:0]   pal_in,
  input logic [N_OUT-1:0]  pal_out
);
  localparam int N_TERMS = N_OUT * TPO;

  int   grp_now;
  logic in_range;
  logic bad_fb;
  logic rst_q;

  always_comb begin
    grp_now  = int'(cfg_addr) / TPO;
    in_range = int'(cfg_addr) < N_TERMS;
    bad_fb   = (cfg_data >> (2 * N_IN + 2 * grp_now)) != '0;
  end

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_OPEN: assert (&pal_out) else $error("outputs not all 1 after reset"); // R4
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(pal_in) -> $stable(pal_out))); // R8

  AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !in_range) |=> ($stable(pal_in) -> $stable(pal_out))); // R6

  AST_FEEDBACK_GUARD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && in_range && bad_fb) |=> ($stable(pal_in) -> $stable(pal_out))); // R7

  AST_EMPTY_TERM_ONE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && in_range && cfg_data == '0)
      |=> (|(pal_out & (N_OUT'(1) << $past(grp_now))))); // R3
endmodule

bind pal_array_top pal_array_chk #(
  .N_IN  (N_IN),
  .N_OUT (N_OUT),
  .TPO   (TPO),
  .ADDR_W(ADDR_W),
  .MASK_W(MASK_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_we  (cfg_we),
  .cfg_addr(cfg_addr),
  .cfg_data(cfg_data),
  .pal_in  (pal_in),
  .pal_out (pal_out)
);

// File: tb/tb_pal_array_top.sv
module tb_pal_array_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_data;
  logic [3:0]  pal_in;
  logic [3:0]  pal_out;

  always #4 clk = ~clk;  // 8 ns period

  pal_array_top dut (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .cfg_data(cfg_data),
    .pal_in  (pal_in),
    .pal_out (pal_out)
  );

  typedef struct {
    logic [3:0] stim;
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;

  // bench view of the loaded map
  bit all_open = 1'b1;
  bit f2_alt   = 1'b0;
  bit f3_one   = 1'b0;

  // masks (R2 bit positions), A..D = pal_in[0..3]
  localparam logic [15:0] M_NC   = 16'h0020; // C'
  localparam logic [15:0] M_NANB = 16'h000A; // A'B'
  localparam logic [15:0] M_ZERO = 16'h0003; // A A' -> 0
  localparam logic [15:0] M_NABNC= 16'h0026; // A'BC'
  localparam logic [15:0] M_AC   = 16'h0011;
  localparam logic [15:0] M_ANB  = 16'h0009; // AB'
  localparam logic [15:0] M_AD   = 16'h0041;
  localparam logic [15:0] M_BD   = 16'h0044;
  localparam logic [15:0] M_O0   = 16'h0100; // out0 true
  localparam logic [15:0] M_AB   = 16'h0005;
  localparam logic [15:0] M_CD   = 16'h0050;
  localparam logic [15:0] M_NO0  = 16'h0200; // out0 complement
  localparam logic [15:0] M_O1   = 16'h0400; // out1 true

  function automatic logic [3:0] model(logic [3:0] s);
    logic a, b, c, d, f1, f2, f3, f4;
    a = s[0]; b = s[1]; c = s[2]; d = s[3];
    if (all_open) return 4'hF;
    f1 = ~c | (~a & ~b);
    if (f2_alt) f2 = f1 | (a & c) | (a & ~b);
    else        f2 = (~a & b & ~c) | (a & c) | (a & ~b);
    f3 = f3_one ? 1'b1 : ((a & d) | (b & d) | f1);
    f4 = (a & b) | (c & d) | ~f1;
    return {f4, f3, f2, f1};
  endfunction

  // monitor: compare one expected item per cycle, away from the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0 && !done) begin
        it = q.pop_front();
        n_checks++;
        if (pal_out !== it.exp) begin
          n_fails++;
          $display("FAIL %s: in=%b actual=%b expected=%b", it.tag, it.stim, pal_out, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic [3:0] s, input string tag);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    pal_in = s;
    q.push_back('{stim: s, exp: model(s), tag: tag});
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0; pal_in = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R4: all-open map after reset
    drive(4'h0, "R4 reset open map");
    drive(4'h5, "R4 reset open map");
    drive(4'hB, "R4 reset open map");

    // load example map: group k -> terms 3k..3k+2
    cfg_write(4'd0, M_NC);   cfg_write(4'd1, M_NANB); cfg_write(4'd2, M_ZERO);
    cfg_write(4'd3, M_NABNC);cfg_write(4'd4, M_AC);   cfg_write(4'd5, M_ANB);
    cfg_write(4'd6, M_AD);   cfg_write(4'd7, M_BD);   cfg_write(4'd8, M_O0);
    cfg_write(4'd9, M_AB);   cfg_write(4'd10, M_CD);  cfg_write(4'd11, M_NO0);
    all_open = 1'b0;

    // R1 R2 R9 and R3 (term 2 forced to 0): full sweep
    for (int v = 0; v < 16; v++) drive(4'(v), "R1 R2 R3 R9 example map");

    // R7: group 0 may not use its own output -> ignored
    cfg_write(4'd0, M_O0);
    drive(4'h0, "R7 self feedback rejected");
    drive(4'h4, "R7 self feedback rejected");
    drive(4'h7, "R7 self feedback rejected");

    // R6: address out of range ignored
    cfg_write(4'd13, 16'h0000);
    cfg_write(4'd12, 16'h0003);
    drive(4'h2, "R6 out of range write ignored");
    drive(4'hC, "R6 out of range write ignored");

    // R7: group 1 may not use out1 -> ignored
    cfg_write(4'd3, M_O1);
    drive(4'h0, "R7 group1 self feedback rejected");
    drive(4'h2, "R7 group1 self feedback rejected");

    // R5: write and evaluation in the same cycle (legal term 3 = out0)
    @(posedge clk); #1;
    pal_in = 4'h0; cfg_we = 1'b1; cfg_addr = 4'd3; cfg_data = M_O0;
    q.push_back('{stim: 4'h0, exp: model(4'h0), tag: "R5 old map during write cycle"});
    f2_alt = 1'b1;
    drive(4'h0, "R5 R7 new map after edge");

    // R7 accepted legal feedback, R9: full sweep with new term
    for (int v = 0; v < 16; v++) drive(4'(v), "R7 R9 legal feedback sweep");

    // R3: empty term makes its output 1
    cfg_write(4'd6, 16'h0000);
    f3_one = 1'b1;
    drive(4'h0, "R3 empty term");
    drive(4'h4, "R3 empty term");
    drive(4'hF, "R3 empty term");

    // R8: repeat inputs with no write
    drive(4'h9, "R8 stable without writes");
    drive(4'h9, "R8 stable without writes");

    // R4: reset again clears the map
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    all_open = 1'b1; f2_alt = 1'b0; f3_one = 1'b0;
    drive(4'h3, "R4 reset clears loaded map");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule